// File: doc/BRIEF.md
# Converter Control Register with Clock Divider

This block is the control and status register that sits beside a converter sequencer. Software programs an interrupt enable and a three-bit divide select through a single-register write port and reads everything back on a read-data bus. The sequencer reports each finished conversion with a one-cycle pulse. The block latches that pulse into a completion flag and raises an interrupt request while the flag and the enable are both set.

The flag is cleared in one of two ways. The interrupt controller can send an acknowledge pulse when it services the vector, or software can write a one into the flag position. The divide select picks how often a one-cycle clock-enable pulse is sent to the converter logic. A free-running counter produces that pulse, and the counter restarts whenever the select takes a new value.

Top module: `cnv_ctrl_reg`

## Requirements
- R1: While the synchronous reset is high, and in the first cycle after it falls, the read data is 0, the interrupt request is 0 and the flag, enable and select fields are all 0.
- R2: A completion pulse sets the flag. The flag reads as 1 on read-data bit 4 from the cycle after the pulse onward.
- R3: The interrupt request is 1 exactly while both the flag (bit 4) and the interrupt enable (bit 3) read as 1.
- R4: An acknowledge pulse clears the flag in the following cycle.
- R5: A write with bit 4 set clears the flag. A write with bit 4 clear leaves the flag unchanged.
- R6: When a completion pulse arrives in the same cycle as an acknowledge or a write that clears the flag, the flag ends up set.
- R7: A write stores write-data bit 3 as the interrupt enable and bits 2:0 as the divide select. Read data returns them in the same positions. Bits 7:5 always read 0.
- R8: The clock-enable output is a single-cycle pulse with period F. F is 2 for select codes 0 and 1, and 2 to the power of the code for codes 2 to 7 (giving 4, 8, 16, 32, 64 and 128).
- R9: A write that changes the select restarts the counter. The first enable pulse then falls in the cycle after the (F-1)-th clock edge that follows the write edge. A write of the same select value leaves the pulse phase unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read data: flag, enable, select |
| done_i | input | 1 | Conversion-complete pulse from the sequencer |
| ack_i | input | 1 | Interrupt-acknowledge pulse from the interrupt controller |
| irq_o | output | 1 | Conversion-complete interrupt request |
| cclk_en_o | output | 1 | One-cycle converter clock enable |

## Verification
A wrong flag value appears on read-data bit 4 one cycle after the event that caused it. If the enable is set, the interrupt request shows the same error in that same cycle. The bench therefore drives every mix of prior flag, enable, completion, acknowledge and write mode, and then reads back after a single edge. A wrong divide factor or a missed restart shows up as an enable pulse in the wrong cycle within at most 128 cycles. Each select code is checked cycle by cycle over three full periods, starting from the write edge.

// File: rtl/cnv_ctrl_pkg.sv
package cnv_ctrl_pkg;

    localparam int unsigned CTRL_W_DEF   = 8;
    localparam int unsigned SEL_W_DEF    = 3;
    localparam int unsigned IE_POS_DEF   = 3;
    localparam int unsigned FLAG_POS_DEF = 4;

    typedef enum logic [1:0] {
        EV_HOLD  = 2'd0,
        EV_SET   = 2'd1,
        EV_CLEAR = 2'd2
    } flag_ev_e;

endpackage

// File: rtl/cnv_flag_unit.sv
module cnv_flag_unit
    import cnv_ctrl_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic set_i,
    input  logic ack_i,
    input  logic wclr_i,
    output logic flag_o
);

    typedef struct packed {
        logic flag;
    } flag_st_t;

    flag_st_t st_d, st_q;
    flag_ev_e ev;

    always_comb begin
        // the set event has priority so that no completion is lost
        if (set_i) begin
            ev = EV_SET;
        end else if (ack_i || wclr_i) begin
            ev = EV_CLEAR;
        end else begin
            ev = EV_HOLD;
        end

        st_d = st_q;
        case (ev)
            EV_SET:   st_d.flag = 1'b1;
            EV_CLEAR: st_d.flag = 1'b0;
            default:  st_d.flag = st_q.flag;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;

endmodule

// File: rtl/cnv_cfg_regs.sv
module cnv_cfg_regs #(
    parameter int unsigned SEL_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             wr_en_i,
    input  logic             ie_wr_i,
    input  logic [SEL_W-1:0] sel_wr_i,
    output logic             ie_o,
    output logic [SEL_W-1:0] sel_o,
    output logic             restart_o
);

    typedef struct packed {
        logic             ie;
        logic [SEL_W-1:0] sel;
    } cfg_st_t;

    cfg_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        restart_o = 1'b0;
        if (wr_en_i) begin
            st_d.ie  = ie_wr_i;
            st_d.sel = sel_wr_i;
            // only a new select value restarts the divider
            restart_o = (sel_wr_i != st_q.sel);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ie_o  = st_q.ie;
    assign sel_o = st_q.sel;

endmodule

// File: rtl/cnv_clk_div.sv
module cnv_clk_div #(
    parameter int unsigned SEL_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             restart_i,
    output logic             tick_o
);

    localparam int unsigned CNT_W = (1 << SEL_W) - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_st_t;

    div_st_t          st_d, st_q;
    logic [CNT_W-1:0] last;

    // terminal count: codes 0 and 1 both divide by two
    function automatic logic [CNT_W-1:0] last_count(input logic [SEL_W-1:0] code);
        logic [CNT_W:0] span;
        span = {{CNT_W{1'b0}}, 1'b1} << code;
        if (code <= SEL_W'(1)) begin
            return CNT_W'(1);
        end
        return span[CNT_W-1:0] - CNT_W'(1);
    endfunction

    always_comb begin
        last = last_count(sel_i);
        st_d = st_q;
        if (restart_i || (st_q.cnt == last)) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = (st_q.cnt == last);

endmodule

// File: rtl/cnv_rd_pack.sv
module cnv_rd_pack #(
    parameter int unsigned CTRL_W   = 8,
    parameter int unsigned SEL_W    = 3,
    parameter int unsigned IE_POS   = 3,
    parameter int unsigned FLAG_POS = 4
) (
    input  logic              flag_i,
    input  logic              ie_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic [CTRL_W-1:0] rd_o
);

    for (genvar b = 0; b < CTRL_W; b++) begin : g_bit
        if (b < SEL_W) begin : g_sel
            assign rd_o[b] = sel_i[b];
        end else if (b == IE_POS) begin : g_ie
            assign rd_o[b] = ie_i;
        end else if (b == FLAG_POS) begin : g_flag
            assign rd_o[b] = flag_i;
        end else begin : g_zero
            assign rd_o[b] = 1'b0;
        end
    end

endmodule

// File: rtl/cnv_ctrl_reg.sv
module cnv_ctrl_reg
    import cnv_ctrl_pkg::*;
#(
    parameter int unsigned CTRL_W   = CTRL_W_DEF,
    parameter int unsigned SEL_W    = SEL_W_DEF,
    parameter int unsigned IE_POS   = IE_POS_DEF,
    parameter int unsigned FLAG_POS = FLAG_POS_DEF
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic [CTRL_W-1:0] wr_data_i,
    output logic [CTRL_W-1:0] rd_data_o,
    input  logic              done_i,
    input  logic              ack_i,
    output logic              irq_o,
    output logic              cclk_en_o
);

    logic             flag;
    logic             ie;
    logic [SEL_W-1:0] sel;
    logic             restart;
    logic             wclr;
    logic             unused_wr_bits;

    assign wclr           = wr_en_i & wr_data_i[FLAG_POS];
    assign unused_wr_bits = ^wr_data_i;

    cnv_flag_unit u_flag (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .set_i  (done_i),
        .ack_i  (ack_i),
        .wclr_i (wclr),
        .flag_o (flag)
    );

    cnv_cfg_regs #(.SEL_W(SEL_W)) u_cfg (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .wr_en_i   (wr_en_i),
        .ie_wr_i   (wr_data_i[IE_POS]),
        .sel_wr_i  (wr_data_i[SEL_W-1:0]),
        .ie_o      (ie),
        .sel_o     (sel),
        .restart_o (restart)
    );

    cnv_clk_div #(.SEL_W(SEL_W)) u_div (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .sel_i     (sel),
        .restart_i (restart),
        .tick_o    (cclk_en_o)
    );

    cnv_rd_pack #(
        .CTRL_W   (CTRL_W),
        .SEL_W    (SEL_W),
        .IE_POS   (IE_POS),
        .FLAG_POS (FLAG_POS)
    ) u_rd (
        .flag_i (flag),
        .ie_i   (ie),
        .sel_i  (sel),
        .rd_o   (rd_data_o)
    );

    assign irq_o = flag & ie;

endmodule

// File: rtl/cnv_ctrl_chk.sv
module cnv_ctrl_chk #(
    parameter int unsigned CTRL_W   = 8,
    parameter int unsigned SEL_W    = 3,
    parameter int unsigned IE_POS   = 3,
    parameter int unsigned FLAG_POS = 4
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              wr_en_i,
    input logic [CTRL_W-1:0] wr_data_i,
    input logic [CTRL_W-1:0] rd_data_o,
    input logic              done_i,
    input logic              ack_i,
    input logic              irq_o,
    input logic              cclk_en_o
);

    p_reset_zero_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(rst_i) |-> (rd_data_o == '0 && !irq_o));

    p_done_sets_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        done_i |=> rd_data_o[FLAG_POS]);

    p_irq_needs_flag_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_o |-> (rd_data_o[FLAG_POS] && rd_data_o[IE_POS]));

    p_ack_clears_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (ack_i && !done_i) |=> !rd_data_o[FLAG_POS]);

    p_write_zero_keeps_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && !wr_data_i[FLAG_POS] && !ack_i && !done_i && rd_data_o[FLAG_POS])
        |=> rd_data_o[FLAG_POS]);

    p_set_wins_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (done_i && (ack_i || (wr_en_i && wr_data_i[FLAG_POS]))) |=> rd_data_o[FLAG_POS]);

    p_single_pulse_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        cclk_en_o |=> !cclk_en_o);

    p_restart_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && (wr_data_i[SEL_W-1:0] != rd_data_o[SEL_W-1:0])) |=> !cclk_en_o);

endmodule

bind cnv_ctrl_reg cnv_ctrl_chk #(
    .CTRL_W   (CTRL_W),
    .SEL_W    (SEL_W),
    .IE_POS   (IE_POS),
    .FLAG_POS (FLAG_POS)
) u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_data_o (rd_data_o),
    .done_i    (done_i),
    .ack_i     (ack_i),
    .irq_o     (irq_o),
    .cclk_en_o (cclk_en_o)
);

// File: tb/cnv_ctrl_reg_tb.sv
module cnv_ctrl_reg_tb;

    logic       clk = 1'b0;
    logic       rst_i;
    logic       wr_en_i;
    logic [7:0] wr_data_i;
    logic [7:0] rd_data_o;
    logic       done_i;
    logic       ack_i;
    logic       irq_o;
    logic       cclk_en_o;

    int  checks = 0;
    int  fails  = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    cnv_ctrl_reg u_dut (
        .clk_i     (clk),
        .rst_i     (rst_i),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .rd_data_o (rd_data_o),
        .done_i    (done_i),
        .ack_i     (ack_i),
        .irq_o     (irq_o),
        .cclk_en_o (cclk_en_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en_i   = 1'b1;
        wr_data_i = d;
        tick();
        wr_en_i   = 1'b0;
        wr_data_i = 8'h00;
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_i = 1'b1; wr_en_i = 1'b0; wr_data_i = 8'h00; done_i = 1'b0; ack_i = 1'b0;
        repeat (3) tick();
        // R1: held in reset
        chk("R1 rd", 32'(rd_data_o), 32'h0);
        chk("R1 irq", 32'(irq_o), 32'h0);
        chk("R1 en", 32'(cclk_en_o), 32'h0);
        rst_i = 1'b0;
        tick();
        // R1 first cycle after release; R8 counter reached 1 of divide-by-2
        chk("R1 rd after", 32'(rd_data_o), 32'h0);
        chk("R1 irq after", 32'(irq_o), 32'h0);
        chk("R8 first pulse", 32'(cclk_en_o), 32'h1);

        // flag sweep: prior flag, enable, done, ack, write mode
        for (int f0 = 0; f0 < 2; f0++) begin
            for (int ie = 0; ie < 2; ie++) begin
                for (int d = 0; d < 2; d++) begin
                    for (int a = 0; a < 2; a++) begin
                        for (int wm = 0; wm < 3; wm++) begin
                            logic  expf;
                            string req;
                            wr({3'b000, 1'b1, ie[0], 3'b000});
                            if (f0 != 0) begin
                                done_i = 1'b1;
                                tick();
                                done_i = 1'b0;
                            end
                            done_i = d[0];
                            ack_i  = a[0];
                            if (wm != 0) begin
                                wr_en_i   = 1'b1;
                                wr_data_i = {3'b000, (wm == 2), ie[0], 3'b000};
                            end
                            tick();
                            done_i = 1'b0; ack_i = 1'b0; wr_en_i = 1'b0; wr_data_i = 8'h00;
                            expf = (d != 0) || ((f0 != 0) && (a == 0) && (wm != 2));
                            if (d != 0 && (a != 0 || wm == 2))      req = "R6";
                            else if (d != 0)                        req = "R2";
                            else if (a != 0)                        req = "R4";
                            else                                    req = "R5";
                            chk(req, 32'(rd_data_o), 32'({3'b000, expf, ie[0], 3'b000}));
                            chk("R3", 32'(irq_o), 32'(expf & ie[0]));
                        end
                    end
                end
            end
        end

        // R7: reserved bits read zero; write-one on bit 4 clears flag
        wr(8'hFF);
        chk("R7 ff", 32'(rd_data_o), 32'h0F);
        wr(8'hE5);
        chk("R7 e5", 32'(rd_data_o), 32'h05);

        // R8/R9: every divide select, from the write edge, three periods
        for (int s = 0; s < 8; s++) begin
            int f;
            wr(8'((s + 1) % 8));
            wr(8'(s));
            f = (s < 2) ? 2 : (1 << s);
            for (int m = 0; m < 3 * f; m++) begin
                chk((m < f) ? "R9 restart" : "R8 period", 32'(cclk_en_o),
                    32'((m % f) == (f - 1)));
                tick();
            end
        end

        // R9: rewriting the same select keeps the phase
        wr(8'h02);
        tick();
        wr(8'h02);
        chk("R9 same m2", 32'(cclk_en_o), 32'h0);
        tick();
        chk("R9 same m3", 32'(cclk_en_o), 32'h1);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule